// File: doc/BRIEF.md
# Legacy Window Memory Access Router

This block sits in a memory controller's address path and chooses, for every physical access, one of three destinations: the display device, the protected management RAM, or ordinary main memory. The choice depends on the address, on whether the requester is currently running in management mode, and on a small configuration register. That register holds an open-override bit and a lock bit.

The fixed legacy window covers 0xA0000 to 0xBFFFF. Outside management mode, accesses to this window normally reach the display device. The same addresses reach the management RAM when the requester is in management mode, or when the open-override bit is set.

The management RAM occupies a 128 KiB region that starts at a relocatable base. The selected destination is registered together with the request. It is passed downstream through a valid/ready handshake that holds the request while it waits.

Top module: `legacy_window_router`

## Requirements
- R1: A window access (0xA0000 to 0xBFFFF inclusive) made outside management mode while the open-override bit is clear selects the display device (outSel = 3'b010).
- R2: A window access made in management mode selects the management RAM (outSel = 3'b100), whatever the override bit is.
- R3: While the open-override bit is set, a window access made outside management mode selects the management RAM.
- R4: An access outside the window that falls between mramBase and mramBase + 0x1FFFF inclusive selects the management RAM when the requester is in management mode or the override bit is set. Otherwise it selects main memory (outSel = 3'b001).
- R5: An access outside both the window and the management region selects main memory, in every mode and with any override setting.
- R6: The window bounds are inclusive and exact: 0x9FFFF and 0xC0000 lie outside the window.
- R7: A configuration write with cfgWrLock = 1 sets the lock and clears the open-override bit. While locked, the override reads as 0 and later configuration writes change nothing until reset.
- R8: An accepted request appears on outAddr and outWrite in the cycle after acceptance, with outValid high and exactly one bit of outSel set.
- R9: A request is accepted only when reqValid and reqReady are both high. reqReady is low while outValid is high and outReady is low, and the pending output stays stable during that time.
- R10: Reset clears outValid, the override bit and the lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Router can take a request |
| reqAddr | input | ADDR_W | Physical address |
| reqWrite | input | 1 | Request is a write |
| reqMgmt | input | 1 | Requester is in management mode |
| mramBase | input | ADDR_W | Base of the management RAM region |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgWrOpen | input | 1 | Open-override value to write |
| cfgWrLock | input | 1 | Lock value to write |
| cfgOpen | output | 1 | Current open-override bit |
| cfgLock | output | 1 | Current lock bit |
| outValid | output | 1 | Forwarded request valid |
| outReady | input | 1 | Downstream takes the forwarded request |
| outAddr | output | ADDR_W | Forwarded address |
| outWrite | output | 1 | Forwarded write flag |
| outSel | output | 3 | One-hot target: bit0 main, bit1 display, bit2 management RAM |

## Verification
The bench probes the window edges at 0x9FFFF, 0xA0000, 0xBFFFF and 0xC0000. A design with an off-by-one compare would send these edge addresses to the wrong target. It moves the management base away from the window and checks the region edges in each mode; a design that ignored the mode outside the window would leak the relocated region to ordinary requests. The bench also tries to reopen the region after locking; a lock that failed to stick would let the display window be shadowed by protected RAM. Finally, it stalls the downstream side and sends a second request; a design that dropped or overwrote a held request would lose or corrupt the first one.

// File: rtl/lwr_pkg.sv
package lwr_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_MAIN  = 3'b001,
    SEL_VIDEO = 3'b010,
    SEL_MRAM  = 3'b100
  } tgtSel_e;

  typedef struct packed {
    logic loadOut;
    logic openEff;
  } ctrlStrobe_t;
endpackage

// File: rtl/lwr_ctrl.sv
module lwr_ctrl
  import lwr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        outReady,
  input  logic        cfgWrEn,
  input  logic        cfgWrOpen,
  input  logic        cfgWrLock,
  output logic        reqReady,
  output logic        outValid,
  output logic        cfgOpen,
  output logic        cfgLock,
  output ctrlStrobe_t strobe
);
  logic accept;

  // Free slot, or the held entry leaves this cycle.
  assign reqReady = ~outValid | outReady;
  assign accept   = reqValid & reqReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
    end else if (accept) begin
      outValid <= 1'b1;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // Setting the lock also drops the override; once locked, writes are ignored.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgOpen <= 1'b0;
      cfgLock <= 1'b0;
    end else if (cfgWrEn && !cfgLock) begin
      cfgOpen <= cfgWrOpen & ~cfgWrLock;
      cfgLock <= cfgWrLock;
    end
  end

  always_comb begin
    strobe.loadOut = accept;
    strobe.openEff = cfgOpen & ~cfgLock;
  end
endmodule

// File: rtl/lwr_datapath.sv
module lwr_datapath
  import lwr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_LO = 'hA0000,
  parameter logic [ADDR_W-1:0] WIN_HI = 'hBFFFF,
  parameter logic [ADDR_W-1:0] MRAM_SPAN = 'h20000
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqMgmt,
  input  logic [ADDR_W-1:0] mramBase,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outWrite,
  output logic [SEL_W-1:0]  outSel
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0] mramTop;
  logic             inWin;
  logic             inMram;
  logic             privileged;
  tgtSel_e          nextSel;

  // One extra bit so that a high base cannot wrap the region's top.
  assign mramTop = {1'b0, mramBase} + EXT_W'(MRAM_SPAN) - EXT_W'(1);

  always_comb begin
    inWin      = (reqAddr >= WIN_LO) && (reqAddr <= WIN_HI);
    inMram     = ({1'b0, reqAddr} >= {1'b0, mramBase}) && ({1'b0, reqAddr} <= mramTop);
    privileged = reqMgmt | strobe.openEff;
    if (inWin) begin
      nextSel = privileged ? SEL_MRAM : SEL_VIDEO;
    end else if (inMram && privileged) begin
      nextSel = SEL_MRAM;
    end else begin
      nextSel = SEL_MAIN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAddr  <= '0;
      outWrite <= 1'b0;
      outSel   <= '0;
    end else if (strobe.loadOut) begin
      outAddr  <= reqAddr;
      outWrite <= reqWrite;
      outSel   <= nextSel;
    end
  end
endmodule

// File: rtl/legacy_window_router.sv
module legacy_window_router
  import lwr_pkg::*;
#(
  parameter int ADDR_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqMgmt,
  input  logic [ADDR_W-1:0] mramBase,
  input  logic              cfgWrEn,
  input  logic              cfgWrOpen,
  input  logic              cfgWrLock,
  output logic              cfgOpen,
  output logic              cfgLock,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outWrite,
  output logic [2:0]        outSel
);
  ctrlStrobe_t strobe;

  lwr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .outReady(outReady),
    .cfgWrEn(cfgWrEn), .cfgWrOpen(cfgWrOpen), .cfgWrLock(cfgWrLock),
    .reqReady(reqReady), .outValid(outValid), .cfgOpen(cfgOpen),
    .cfgLock(cfgLock), .strobe(strobe)
  );

  lwr_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqMgmt(reqMgmt), .mramBase(mramBase),
    .outAddr(outAddr), .outWrite(outWrite), .outSel(outSel)
  );
endmodule

// File: rtl/lwr_checker.sv
module lwr_checker #(
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqWrite,
  input logic              reqMgmt,
  input logic              cfgOpen,
  input logic              cfgLock,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outAddr,
  input logic              outWrite,
  input logic [2:0]        outSel
);
  assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(outSel) == 1));

  assert_accept_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (outValid && outAddr == $past(reqAddr) && outWrite == $past(reqWrite)));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outAddr) && $stable(outSel)));

  assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !reqReady);

  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgLock |=> (cfgLock && !cfgOpen));

  assert_mgmt_no_video_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqMgmt) |=> (outSel != 3'b010));
endmodule

bind legacy_window_router lwr_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/legacy_window_router_bench.sv
`timescale 1ns/1ps
module legacy_window_router_bench;
  localparam int AW = 32;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  logic rstN, reqValid, reqReady, reqWrite, reqMgmt;
  logic cfgWrEn, cfgWrOpen, cfgWrLock, cfgOpen, cfgLock;
  logic outValid, outReady, outWrite;
  logic [AW-1:0] reqAddr, mramBase, outAddr;
  logic [2:0] outSel;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  legacy_window_router u_legacy_window_router (.*);

  // {addr, mgmt, open, base, expected sel}; sel bit0 main, bit1 display, bit2 mgmt RAM
  localparam logic [68:0] VECS [NVEC] = '{
    {32'h000A0000, 1'b0, 1'b0, 32'h000A0000, 3'b010},   // R1
    {32'h000BFFFF, 1'b0, 1'b0, 32'h000A0000, 3'b010},   // R1 R6
    {32'h000A0000, 1'b1, 1'b0, 32'h000A0000, 3'b100},   // R2
    {32'h000B1234, 1'b1, 1'b0, 32'h000A0000, 3'b100},   // R2
    {32'h000A8000, 1'b0, 1'b1, 32'h000A0000, 3'b100},   // R3
    {32'h0009FFFF, 1'b1, 1'b0, 32'h000A0000, 3'b001},   // R6
    {32'h000C0000, 1'b1, 1'b1, 32'h000A0000, 3'b001},   // R6
    {32'h00030000, 1'b1, 1'b0, 32'h00030000, 3'b100},   // R4
    {32'h0004FFFF, 1'b0, 1'b0, 32'h00030000, 3'b001},   // R4
    {32'h0004FFFF, 1'b0, 1'b1, 32'h00030000, 3'b100},   // R4
    {32'h00050000, 1'b1, 1'b1, 32'h00030000, 3'b001},   // R5
    {32'h000A0000, 1'b1, 1'b0, 32'h00030000, 3'b100},   // R2
    {32'h000A0000, 1'b0, 1'b0, 32'h00030000, 3'b010},   // R1
    {32'h00001000, 1'b1, 1'b1, 32'h000A0000, 3'b001}    // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic o, input logic l);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrOpen = o; cfgWrLock = l;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendReq(input logic [AW-1:0] a, input logic m, input logic w);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqMgmt = m; reqWrite = w;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqWrite = 1'b0; reqMgmt = 1'b0;
    mramBase = 32'h000A0000; cfgWrEn = 1'b0; cfgWrOpen = 1'b0; cfgWrLock = 1'b0;
    outReady = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 outValid", 32'(outValid), 32'd0);
    check("R10 cfgOpen", 32'(cfgOpen), 32'd0);
    check("R10 cfgLock", 32'(cfgLock), 32'd0);
    check("R9 ready idle", 32'(reqReady), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      mramBase = VECS[i][34:3];
      cfgWrite(VECS[i][35], 1'b0);
      sendReq(VECS[i][68:37], VECS[i][36], i[0]);
      check($sformatf("R8 valid vec%0d", i), 32'(outValid), 32'd1);
      check($sformatf("R1-5 sel vec%0d", i), 32'(outSel), 32'(VECS[i][2:0]));
      check($sformatf("R8 addr vec%0d", i), outAddr, VECS[i][68:37]);
      check($sformatf("R8 write vec%0d", i), 32'(outWrite), 32'(i[0]));
    end

    // R9: stall downstream, second request must wait, first held
    mramBase = 32'h000A0000;
    cfgWrite(1'b0, 1'b0);
    @(negedge clk);
    outReady = 1'b0;
    sendReq(32'h000A1111, 1'b0, 1'b1);
    check("R9 held valid", 32'(outValid), 32'd1);
    check("R9 ready low", 32'(reqReady), 32'd0);
    reqValid = 1'b1; reqAddr = 32'h00200000; reqMgmt = 1'b0; reqWrite = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 addr held", outAddr, 32'h000A1111);
    check("R9 sel held", 32'(outSel), 32'h2);
    outReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R9 second addr", outAddr, 32'h00200000);
    check("R9 second sel", 32'(outSel), 32'h1);
    @(negedge clk);
    check("R9 drained", 32'(outValid), 32'd0);

    // R7: lock clears override and ignores later writes
    cfgWrite(1'b1, 1'b0);
    check("R3 open set", 32'(cfgOpen), 32'd1);
    cfgWrite(1'b1, 1'b1);
    check("R7 locked", 32'(cfgLock), 32'd1);
    check("R7 open cleared", 32'(cfgOpen), 32'd0);
    cfgWrite(1'b1, 1'b0);
    check("R7 write ignored open", 32'(cfgOpen), 32'd0);
    check("R7 write ignored lock", 32'(cfgLock), 32'd1);
    sendReq(32'h000A4000, 1'b0, 1'b0);
    check("R7 window to display", 32'(outSel), 32'h2);
    sendReq(32'h000A4000, 1'b1, 1'b0);
    check("R7 mgmt still RAM", 32'(outSel), 32'h4);

    doReset();
    @(negedge clk);
    check("R10 lock cleared", 32'(cfgLock), 32'd0);
    check("R10 valid cleared", 32'(outValid), 32'd0);
    cfgWrite(1'b1, 1'b0);
    check("R7 writable after reset", 32'(cfgOpen), 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule